// File: doc/BRIEF.md
# Prioritised Task Dispatcher

This block schedules work for a small microcoded processor that runs as a set of cooperative event handlers. Peripheral events arrive on eight request lines. Typical sources are serial bit-engine events, byte-ready and byte-needed strobes, a host parameter write and a disc index pulse. Each request sets a sticky pending flag. Each task slot also holds a callback routine number. The processor never polls the request lines. When it gives up control with a yield, the dispatcher selects the most urgent pending request that is enabled. It then presents a (task, routine) key, which a jump-target lookup outside this block turns into a code address.

The processor can rebind the callback of any task. It can also rebind its own callback and yield in the same instruction. A command-exit operation disables every event and returns every callback to routine 0. When nothing is eligible, the dispatcher reports idle. It then waits until an enabled request becomes pending and dispatches that request by itself one clock later.

Top module: `task_dispatcher`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `idle_o` is 1, `dispatch_o` is 0, `key_task_o` and `key_routine_o` are 0, the enable mask is all zero and every stored routine number is 0.
- R2: A 1 on `req_i[i]` at a clock edge sets pending flag i. The flag stays set over any number of cycles until task i is dispatched.
- R3: On `yield_i`, the candidate set is the pending flags ANDed with the enable mask. If that set is not empty, the lowest set index wins (index 0 is most urgent). After the next edge, `dispatch_o` is 1 for one cycle, `key_task_o` holds the winning index and `key_routine_o` holds that task's routine number.
- R4: A yield that finds no candidate sets `idle_o` to 1 after the next edge, with `dispatch_o` 0. A dispatch clears `idle_o`.
- R5: While idle, a request sampled at edge k leads to a dispatch at edge k+1, with no yield needed.
- R6: A pending request whose mask bit is 0 is never selected and stays pending. `mask_we_i` loads `mask_i` at the edge. A yield, or the idle check, in that same cycle uses the old mask.
- R7: `bind_i` writes `bind_routine_i` as the routine number of task `bind_task_i`. Later dispatches of that task report the new value.
- R8: `yieldto_i`, while not idle, writes `yieldto_routine_i` as the routine of the task in `key_task_o` and yields in the same cycle. If that task wins, the new routine is reported. When it meets a `bind_i` to the same task, `yieldto_i` wins.
- R9: `exit_i` has priority over all other inputs. At the edge it clears the enable mask, resets all routine numbers to 0, sets `idle_o` and blocks any dispatch. Pending flags are kept.
- R10: A dispatch clears the winner's pending flag, unless `req_i` for that index is 1 in the same cycle. In that case the flag stays set.
- R11: In a cycle with no dispatch, `key_task_o` and `key_routine_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Event request lines, one per task |
| mask_we_i | input | 1 | Load the enable mask |
| mask_i | input | 8 | New enable mask |
| yield_i | input | 1 | Processor yields |
| yieldto_i | input | 1 | Rebind the current task's routine and yield |
| yieldto_routine_i | input | 4 | Routine for the yield-and-rebind |
| bind_i | input | 1 | Rebind the routine of a named task |
| bind_task_i | input | 3 | Task to rebind |
| bind_routine_i | input | 4 | Routine to store |
| exit_i | input | 1 | Command exit: disable events, reset callbacks |
| dispatch_o | output | 1 | One-cycle pulse when a new key is issued |
| idle_o | output | 1 | Processor has nothing to run |
| key_task_o | output | 3 | Task part of the lookup key |
| key_routine_o | output | 4 | Routine part of the lookup key |

## Verification
Directed sequences cover the following cases:
- two simultaneous requests with different indices, which shows that priority goes by index rather than arrival;
- a request against a cleared mask bit, which separates "pending" from "eligible";
- a re-request in the same cycle as its own dispatch;
- a yield-and-rebind that re-selects the same task, which shows whether the rebind is visible in the issued key;
- an exit followed by a mask reload, which shows that pending flags survive while callbacks do not.

A long seeded random mix of sparse requests, yields, rebinds, mask writes and rare exits is then compared cycle by cycle against a bench model. This covers collisions that the directed cases do not reach, such as a bind and a yield-and-rebind hitting the same task in the same cycle.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  // Per-entry update chosen for a callback slot in one cycle
  typedef enum logic [1:0] {
    CB_KEEP    = 2'd0,
    CB_BIND    = 2'd1,
    CB_YIELDTO = 2'd2,
    CB_CLEAR   = 2'd3
  } cb_op_e;
endpackage

// File: rtl/td_pending_bank.sv
module td_pending_bank #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_i,
  input  logic          clr_valid_i,
  input  logic [IW-1:0] clr_idx_i,
  output logic [N-1:0]  pend_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic hit;
    assign hit = clr_valid_i && (clr_idx_i == IW'(i));
    always_ff @(posedge clk) begin
      if (rst)           pend_o[i] <= 1'b0;
      else if (req_i[i]) pend_o[i] <= 1'b1;   // new event beats the clear
      else if (hit)      pend_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/td_priority_pick.sv
module td_priority_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  // Scan from the top so the lowest set index is written last
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/td_callback_table.sv
module td_callback_table
  import dispatch_pkg::*;
#(
  parameter int N  = 8,
  parameter int RW = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          bind_we_i,
  input  logic [IW-1:0] bind_task_i,
  input  logic [RW-1:0] bind_rt_i,
  input  logic          yt_we_i,
  input  logic [IW-1:0] yt_task_i,
  input  logic [RW-1:0] yt_rt_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [RW-1:0] rd_rt_o
);
  logic [RW-1:0] slot_q   [N];
  logic [RW-1:0] slot_nxt [N];

  for (genvar i = 0; i < N; i++) begin : g_slot
    cb_op_e op;
    always_comb begin
      if (clear_i)                                   op = CB_CLEAR;
      else if (yt_we_i && yt_task_i == IW'(i))       op = CB_YIELDTO;
      else if (bind_we_i && bind_task_i == IW'(i))   op = CB_BIND;
      else                                           op = CB_KEEP;
      unique case (op)
        CB_CLEAR:   slot_nxt[i] = '0;
        CB_YIELDTO: slot_nxt[i] = yt_rt_i;
        CB_BIND:    slot_nxt[i] = bind_rt_i;
        default:    slot_nxt[i] = slot_q[i];
      endcase
    end
    always_ff @(posedge clk) begin
      if (rst) slot_q[i] <= '0;
      else     slot_q[i] <= slot_nxt[i];
    end
  end

  // Read the post-update value so a same-cycle rebind is seen by the dispatch
  assign rd_rt_o = slot_nxt[rd_idx_i];
endmodule

// File: rtl/task_dispatcher.sv
module task_dispatcher #(
  parameter int N  = 8,
  parameter int RW = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_i,
  input  logic          mask_we_i,
  input  logic [N-1:0]  mask_i,
  input  logic          yield_i,
  input  logic          yieldto_i,
  input  logic [RW-1:0] yieldto_routine_i,
  input  logic          bind_i,
  input  logic [IW-1:0] bind_task_i,
  input  logic [RW-1:0] bind_routine_i,
  input  logic          exit_i,
  output logic          dispatch_o,
  output logic          idle_o,
  output logic [IW-1:0] key_task_o,
  output logic [RW-1:0] key_routine_o
);
  logic [N-1:0]  pend_q;
  logic [N-1:0]  mask_q;
  logic [N-1:0]  cand;
  logic          win_valid;
  logic [IW-1:0] win_idx;
  logic [RW-1:0] win_rt;
  logic          go;
  logic          fire;
  logic          yt_we;

  assign cand  = pend_q & mask_q;
  assign go    = !exit_i && (idle_o || yield_i || yieldto_i);
  assign fire  = go && win_valid;
  assign yt_we = yieldto_i && !idle_o;

  td_pending_bank #(.N(N), .IW(IW)) u_pend (
    .clk(clk), .rst(rst), .req_i(req_i),
    .clr_valid_i(fire), .clr_idx_i(win_idx), .pend_o(pend_q)
  );

  td_priority_pick #(.N(N), .IW(IW)) u_pick (
    .vec_i(cand), .valid_o(win_valid), .idx_o(win_idx)
  );

  td_callback_table #(.N(N), .RW(RW), .IW(IW)) u_cb (
    .clk(clk), .rst(rst), .clear_i(exit_i),
    .bind_we_i(bind_i), .bind_task_i(bind_task_i), .bind_rt_i(bind_routine_i),
    .yt_we_i(yt_we), .yt_task_i(key_task_o), .yt_rt_i(yieldto_routine_i),
    .rd_idx_i(win_idx), .rd_rt_o(win_rt)
  );

  always_ff @(posedge clk) begin
    if (rst)            mask_q <= '0;
    else if (exit_i)    mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dispatch_o    <= 1'b0;
      idle_o        <= 1'b1;
      key_task_o    <= '0;
      key_routine_o <= '0;
    end else begin
      dispatch_o <= fire;
      if (fire) begin
        key_task_o    <= win_idx;
        key_routine_o <= win_rt;
        idle_o        <= 1'b0;
      end else if (exit_i || go) begin
        idle_o <= 1'b1;
      end
    end
  end

  // ---------------- assertions ----------------
  logic [N-1:0] win_below;
  logic [N-1:0] key_onehot;
  assign win_below  = (N'(1) << win_idx) - N'(1);
  assign key_onehot = N'(1) << key_task_o;

  a_r3_pick_lowest: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> ((cand & (N'(1) << win_idx)) != '0) && ((cand & win_below) == '0));

  a_r4_dispatch_not_idle: assert property (@(posedge clk) disable iff (rst)
    dispatch_o |-> !idle_o);

  a_r6_masked_never_won: assert property (@(posedge clk) disable iff (rst)
    dispatch_o |-> (($past(mask_q) & key_onehot) != '0));

  a_r9_exit_stops: assert property (@(posedge clk) disable iff (rst)
    exit_i |=> idle_o && !dispatch_o && (mask_q == '0));

  a_r10_pending_cleared: assert property (@(posedge clk) disable iff (rst)
    dispatch_o |-> ((pend_q & key_onehot) == '0) || (($past(req_i) & key_onehot) != '0));

  a_r11_key_holds: assert property (@(posedge clk) disable iff (rst)
    !dispatch_o |-> $stable(key_task_o) && $stable(key_routine_o));
endmodule

// File: tb/task_dispatcher_test.sv
`timescale 1ns/1ps
module task_dispatcher_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] req;
  logic       mwe;
  logic [7:0] mval;
  logic       yld, ytg;
  logic [3:0] ytr;
  logic       bnd;
  logic [2:0] btk;
  logic [3:0] brt;
  logic       ext;
  logic       disp, idle;
  logic [2:0] ktask;
  logic [3:0] krt;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  task_dispatcher #(.N(8), .RW(4)) uut (
    .clk(clk), .rst(rst), .req_i(req), .mask_we_i(mwe), .mask_i(mval),
    .yield_i(yld), .yieldto_i(ytg), .yieldto_routine_i(ytr),
    .bind_i(bnd), .bind_task_i(btk), .bind_routine_i(brt), .exit_i(ext),
    .dispatch_o(disp), .idle_o(idle), .key_task_o(ktask), .key_routine_o(krt)
  );

  // reference model state
  logic [7:0] m_pend, m_mask;
  logic [3:0] m_tbl [8];
  logic       m_idle, m_disp;
  logic [2:0] m_kt;
  logic [3:0] m_kr;

  task automatic model_reset();
    m_pend = '0; m_mask = '0; m_idle = 1'b1; m_disp = 1'b0; m_kt = '0; m_kr = '0;
    for (int i = 0; i < 8; i++) m_tbl[i] = '0;
  endtask

  task automatic model_step();
    logic [3:0] tn [8];
    logic [7:0] cand;
    logic       go, found;
    int         win;
    for (int i = 0; i < 8; i++) begin
      if (ext)                                 tn[i] = '0;
      else if (ytg && !m_idle && m_kt == 3'(i)) tn[i] = ytr;
      else if (bnd && btk == 3'(i))             tn[i] = brt;
      else                                     tn[i] = m_tbl[i];
    end
    go = !ext && (m_idle || yld || ytg);
    cand = m_pend & m_mask;
    found = 1'b0; win = 0;
    for (int i = 7; i >= 0; i--) if (cand[i]) begin found = 1'b1; win = i; end
    m_disp = go && found;
    if (m_disp) begin
      m_kt = 3'(win); m_kr = tn[win]; m_idle = 1'b0;
    end else if (ext || go) m_idle = 1'b1;
    m_pend = req | (m_pend & ~(m_disp ? (8'd1 << win) : 8'd0));
    if (ext) m_mask = '0; else if (mwe) m_mask = mval;
    for (int i = 0; i < 8; i++) m_tbl[i] = tn[i];
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic expect_out(input string tag, input int d, input int i, input int kt, input int kr);
    check(tag, "dispatch", int'(disp), d);
    check(tag, "idle", int'(idle), i);
    check(tag, "key_task", int'(ktask), kt);
    check(tag, "key_routine", int'(krt), kr);
  endtask

  // one cycle: drive at negedge, model at posedge, return at next negedge
  task automatic step(input logic [7:0] rq, input logic mw, input logic [7:0] mv,
                      input logic y, input logic yt, input logic [3:0] ytrv,
                      input logic bd, input logic [2:0] bt, input logic [3:0] br,
                      input logic ex);
    req = rq; mwe = mw; mval = mv; yld = y; ytg = yt; ytr = ytrv;
    bnd = bd; btk = bt; brt = br; ext = ex;
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle_step(); step(8'h00, 0, 8'h00, 0, 0, 4'd0, 0, 3'd0, 4'd0, 0); endtask
  task automatic yield_step(input logic [7:0] rq); step(rq, 0, 8'h00, 1, 0, 4'd0, 0, 3'd0, 4'd0, 0); endtask

  initial begin : watchdog
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    req = '0; mwe = 0; mval = '0; yld = 0; ytg = 0; ytr = '0;
    bnd = 0; btk = '0; brt = '0; ext = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_out("R1", 0, 1, 0, 0);
    rst = 1'b0;

    // R1: mask is zero after reset, so a request is not taken
    step(8'h01, 0, 8'h00, 0, 0, 4'd0, 0, 3'd0, 4'd0, 0);
    idle_step();
    expect_out("R1", 0, 1, 0, 0);
    // enable all; request 0 now dispatches one edge after the mask load
    step(8'h00, 1, 8'hFF, 0, 0, 4'd0, 0, 3'd0, 4'd0, 0);
    idle_step();
    expect_out("R2", 1, 0, 0, 0);

    // R5: idle then request 5 -> pending at edge k, dispatch at k+1
    yield_step(8'h00);
    expect_out("R4", 0, 1, 0, 0);
    step(8'h20, 0, 8'h00, 0, 0, 4'd0, 0, 3'd0, 4'd0, 0);
    expect_out("R5", 0, 1, 0, 0);
    idle_step();
    expect_out("R5", 1, 0, 5, 0);

    // R7/R3: bind task 2 -> 9, requests 2 and 6 together
    step(8'h44, 0, 8'h00, 0, 0, 4'd0, 1, 3'd2, 4'd9, 0);
    expect_out("R11", 0, 0, 5, 0);
    yield_step(8'h00);
    expect_out("R7", 1, 0, 2, 9);
    idle_step();
    expect_out("R11", 0, 0, 2, 9);
    yield_step(8'h00);
    expect_out("R3", 1, 0, 6, 0);
    yield_step(8'h00);
    expect_out("R4", 0, 1, 6, 0);

    // R6: request 7 while its mask bit is off
    step(8'h80, 1, 8'h7F, 0, 0, 4'd0, 0, 3'd0, 4'd0, 0);
    idle_step();
    expect_out("R6", 0, 1, 6, 0);
    step(8'h00, 1, 8'hFF, 0, 0, 4'd0, 0, 3'd0, 4'd0, 0);
    expect_out("R6", 0, 1, 6, 0);
    idle_step();
    expect_out("R2", 1, 0, 7, 0);

    // R8: yield-and-rebind re-selects task 7 with the new routine
    step(8'h80, 0, 8'h00, 0, 0, 4'd0, 0, 3'd0, 4'd0, 0);
    step(8'h00, 0, 8'h00, 0, 1, 4'd3, 1, 3'd7, 4'd12, 0);
    expect_out("R8", 1, 0, 7, 3);

    // R10: re-request in the same cycle as its own dispatch
    step(8'h10, 0, 8'h00, 0, 0, 4'd0, 0, 3'd0, 4'd0, 0);
    yield_step(8'h10);
    expect_out("R10", 1, 0, 4, 0);
    yield_step(8'h00);
    expect_out("R10", 1, 0, 4, 0);
    yield_step(8'h00);
    expect_out("R4", 0, 1, 4, 0);

    // R9: exit clears mask and callbacks, keeps pending
    step(8'h00, 0, 8'h00, 0, 0, 4'd0, 1, 3'd3, 4'd5, 0);
    step(8'h08, 0, 8'h00, 0, 0, 4'd0, 0, 3'd0, 4'd0, 1);
    expect_out("R9", 0, 1, 4, 0);
    idle_step();
    expect_out("R9", 0, 1, 4, 0);
    step(8'h00, 1, 8'hFF, 0, 0, 4'd0, 0, 3'd0, 4'd0, 0);
    idle_step();
    expect_out("R9", 1, 0, 3, 0);

    // random mix checked against the model
    void'($urandom(32'd4242));
    for (int c = 0; c < 4000; c++) begin
      logic [7:0] rq;
      rq = ($urandom % 5 == 0) ? (8'd1 << ($urandom % 8)) : 8'h00;
      if ($urandom % 40 == 0) rq = 8'($urandom);
      step(rq, ($urandom % 12 == 0), 8'($urandom), ($urandom % 4 == 0),
           ($urandom % 9 == 0), 4'($urandom), ($urandom % 6 == 0),
           3'($urandom), 4'($urandom), ($urandom % 70 == 0));
      checks++;
      if (disp !== m_disp || idle !== m_idle || ktask !== m_kt || krt !== m_kr) begin
        errors++;
        $display("FAIL R3 random cycle %0d: actual d%0d i%0d t%0d r%0d expected d%0d i%0d t%0d r%0d",
                 c, disp, idle, ktask, krt, m_disp, m_idle, m_kt, m_kr);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule